// File: doc/BRIEF.md
# Multi-lane margin sweep sequencer

This block is a host-side controller that walks a group of receiver lanes through a margin sweep in a single direction. It talks to the lane margining registers through a simple request/response port. Each request names a lane, says whether it writes the lane's control word or reads the lane's status word, and carries 16 bits of write data. The far side answers with a one-cycle done pulse and, for reads, the status word.

After a start pulse the block captures its configuration: receiver number, sweep direction, number of lanes, total step count, error limit and dwell time. It then runs a fixed setup sequence on every lane and sweeps the step count upward on all lanes in lockstep. A lane leaves the sweep at its first failing step. Once the sweep ends, a fixed restore sequence runs on every lane. For each lane the block holds the last step that passed and a result code until the next start.

Command and status words share one layout: bits 2:0 hold the receiver number, bits 5:3 the command type, bits 7:6 are zero and bits 15:8 hold the payload. A status word returned for a step carries the error count in bits 13:8 and the margin status in bits 15:14. The direction is encoded as 0 timing-left, 1 timing-right, 2 voltage-up and 3 voltage-down. The result codes are 0 for a lane not in the sweep, 1 for a lane that reached the full total, 2 for a negative acknowledge and 3 for a lane stopped by its limit.

Top module: `margin_sweep_seq`

## Requirements
- R1: After start, each lane from 0 up to the lane count minus one receives, in ascending lane order, three control writes. These are the idle word 0x9C38 (payload 0x9C, type 7, receiver 0), then {2'b11, limit, 2'b00, type 2, receiver}, then 0x9C38. Each write is followed by a status read of the same lane. Every control word has bits 7:6 at zero.
- R2: The step value starts at 1 and rises by one per iteration. A new iteration begins only while at least one lane is alive and the previous step is below the total. No control write is made beyond the expected sequence.
- R3: A timing step word is {1'b0, left, step[5:0], 2'b00, 3'd3, receiver}, where left is 1 only for direction 0. A voltage step word is {down, step[6:0], 2'b00, 3'd4, receiver}, where down is 1 only for direction 3.
- R4: In each iteration the step word is written to the alive lanes in ascending order. The first status read request starts more than the dwell cycle count after the last step write completes.
- R5: A status read counts as a pass only when all of the following hold: the type is 3 for timing or 4 for voltage, the receiver matches, the margin status is 2, and the error count is at most the limit (an error count equal to the limit passes). A pass is followed by an idle-word write and a read-back. The step fails unless the read-back equals 0x9C38.
- R6: A failing lane is dead from then on, with no further step or idle-word writes in the sweep. Its recorded step is the current step minus one. Its code is 2 when the margin status was 1 or 3, and 3 for every other failure, including a bad idle-word read-back.
- R7: A lane that never fails records the step total with code 1. A total of 0 gives step 0, code 1 and no step writes.
- R8: After the sweep, each lane in ascending order receives five control writes, each followed by a status read: 0x9C38, {8'h55, 2'b00, 3'd2, receiver}, 0x9C38, {8'h0F, 2'b00, 3'd2, receiver}, 0x9C38.
- R9: done is high for exactly one cycle after the restore sequence completes, and busy falls on the next cycle. No request is made while the block is idle.
- R10: A start pulse while busy is ignored: the run in progress keeps its captured configuration and produces exactly one done.
- R11: On start, lanes at or beyond the lane count are cleared to step 0 and code 0. A lane count of 0, or one above the lane number parameter, means all lanes. The results stay unchanged from done until the next accepted start.
- R12: A request keeps its lane, direction and write data stable until the done response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| recv_sel | input | 3 | Receiver number placed in every command |
| sweep_dir | input | 2 | 0 timing-left, 1 timing-right, 2 voltage-up, 3 voltage-down |
| lane_cnt | input | LANE_W+1 | Number of lanes swept, starting at lane 0 |
| step_total | input | 7 | Highest step attempted |
| err_limit | input | 6 | Largest error count that still passes |
| dwell_cycles | input | DWELL_W | Wait between the step writes and the status reads |
| req | output | 1 | Register access request |
| req_write | output | 1 | 1 writes the control word, 0 reads the status word |
| req_lane | output | LANE_W | Lane addressed by the request |
| req_wdata | output | 16 | Control word to write |
| rsp_done | input | 1 | One-cycle completion of the current request |
| rsp_rdata | input | 16 | Status word, valid with rsp_done on reads |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| lane_steps | output | NUM_LANES*7 | Last passing step per lane, lane 0 in the low bits |
| lane_result | output | NUM_LANES*2 | Result code per lane, lane 0 in the low bits |

## Verification
The assertions check on every cycle that a request stays stable until it is answered and that the block is quiet while idle. They also check that done is a single-cycle pulse that ends busy, that results do not move while idle without a start, and that no step word ever reaches a dead lane. Only the bench scenarios can show the full ordering of the setup, step and restore writes, the encoding of each direction flag, and the dwell gap. The same holds for the step and code a lane records under each failure kind: negative acknowledge on either status value, error count one above the limit, wrong type, wrong receiver, zero status and a bad idle-word echo. The scenarios also cover early termination when every lane is dead, a zero total, and a start pulse that arrives mid-run.

// File: rtl/margin_sweep_seq.sv
module margin_sweep_seq #(
  parameter int NUM_LANES = 32,
  parameter int DWELL_W = 16,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int CNT_W = LANE_W + 1,
  localparam int STEP_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [2:0]                  recv_sel,
  input  logic [1:0]                  sweep_dir,
  input  logic [CNT_W-1:0]            lane_cnt,
  input  logic [STEP_W-1:0]           step_total,
  input  logic [5:0]                  err_limit,
  input  logic [DWELL_W-1:0]          dwell_cycles,
  output logic                        req,
  output logic                        req_write,
  output logic [LANE_W-1:0]           req_lane,
  output logic [15:0]                 req_wdata,
  input  logic                        rsp_done,
  input  logic [15:0]                 rsp_rdata,
  output logic                        busy,
  output logic                        done,
  output logic [NUM_LANES*STEP_W-1:0] lane_steps,
  output logic [NUM_LANES*2-1:0]      lane_result
);

  localparam logic [15:0] IDLE_WORD = 16'h9C38;
  localparam logic [1:0] RES_THR = 2'd1, RES_NAK = 2'd2, RES_LIM = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_SEQ, S_ITER, S_STEP, S_DWELL, S_STAT, S_ECHO_W, S_ECHO_R, S_FIN
  } state_t;

  state_t               st;
  logic                 post, ph;
  logic [2:0]           seq;
  logic [LANE_W-1:0]    lidx;
  logic [CNT_W-1:0]     nl;
  logic [STEP_W-1:0]    step, c_total;
  logic [DWELL_W-1:0]   cnt, c_dwell;
  logic [NUM_LANES-1:0] alive;
  logic [2:0]           c_recv;
  logic [1:0]           c_dir;
  logic [5:0]           c_lim;

  logic [15:0]      seq_word, step_word;
  logic             seq_last, lane_last, stat_ok, nak, lane_on, timing;
  logic [CNT_W-1:0] nl_n;

  assign timing    = ~c_dir[1];
  assign lane_on   = alive[lidx];
  assign lane_last = ({1'b0, lidx} + CNT_W'(1)) == nl;
  assign seq_last  = post ? (seq == 3'd4) : (seq == 3'd2);
  assign nl_n      = (lane_cnt == '0 || lane_cnt > CNT_W'(NUM_LANES)) ? CNT_W'(NUM_LANES) : lane_cnt;

  assign step_word = timing ? {1'b0, c_dir == 2'd0, step[5:0], 2'b00, 3'd3, c_recv}
                            : {c_dir == 2'd3, step, 2'b00, 3'd4, c_recv};

  always_comb begin
    seq_word = IDLE_WORD;
    if (post) begin
      if (seq == 3'd1) seq_word = {8'h55, 2'b00, 3'd2, c_recv};
      if (seq == 3'd3) seq_word = {8'h0F, 2'b00, 3'd2, c_recv};
    end else if (seq == 3'd1) begin
      seq_word = {2'b11, c_lim, 2'b00, 3'd2, c_recv};
    end
  end

  assign stat_ok = (rsp_rdata[5:3] == (timing ? 3'd3 : 3'd4)) && (rsp_rdata[2:0] == c_recv)
                && (rsp_rdata[15:14] == 2'd2) && (rsp_rdata[13:8] <= c_lim);
  assign nak     = (rsp_rdata[15:14] == 2'd1) || (rsp_rdata[15:14] == 2'd3);

  assign req = (st == S_SEQ) || st == S_ECHO_W || st == S_ECHO_R
            || ((st == S_STEP || st == S_STAT) && lane_on);
  assign req_write = (st == S_SEQ && !ph) || st == S_STEP || st == S_ECHO_W;
  assign req_lane  = lidx;
  assign req_wdata = (st == S_SEQ) ? seq_word : (st == S_STEP) ? step_word : IDLE_WORD;
  assign busy = st != S_IDLE;
  assign done = st == S_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; post <= 1'b0; ph <= 1'b0; seq <= '0; lidx <= '0; nl <= '0;
      step <= '0; c_total <= '0; cnt <= '0; c_dwell <= '0; alive <= '0;
      c_recv <= '0; c_dir <= '0; c_lim <= '0;
      lane_steps <= '0; lane_result <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          c_recv <= recv_sel; c_dir <= sweep_dir; c_total <= step_total;
          c_lim <= err_limit; c_dwell <= dwell_cycles; nl <= nl_n;
          step <= '0; lidx <= '0; seq <= '0; ph <= 1'b0; post <= 1'b0;
          for (int i = 0; i < NUM_LANES; i++) begin
            alive[i] <= (i < int'(nl_n));
            lane_steps[i*STEP_W +: STEP_W] <= (i < int'(nl_n)) ? step_total : '0;
            lane_result[i*2 +: 2] <= (i < int'(nl_n)) ? RES_THR : 2'd0;
          end
          st <= S_SEQ;
        end
        S_SEQ: if (rsp_done) begin
          ph <= ~ph;
          if (ph) begin
            if (!seq_last) seq <= seq + 3'd1;
            else begin
              seq <= '0;
              if (!lane_last) lidx <= lidx + 1'b1;
              else begin
                lidx <= '0;
                st <= post ? S_FIN : S_ITER;
              end
            end
          end
        end
        S_ITER: begin
          lidx <= '0;
          if (alive != '0 && step < c_total) begin
            step <= step + 1'b1;
            st <= S_STEP;
          end else begin
            seq <= '0; ph <= 1'b0; post <= 1'b1;
            st <= S_SEQ;
          end
        end
        S_STEP: if (!lane_on || rsp_done) begin
          if (lane_last) begin
            cnt <= c_dwell;
            st <= S_DWELL;
          end else lidx <= lidx + 1'b1;
        end
        S_DWELL: begin
          if (cnt == '0) begin
            lidx <= '0;
            st <= S_STAT;
          end else cnt <= cnt - 1'b1;
        end
        S_STAT: if (!lane_on || rsp_done) begin
          if (lane_on && stat_ok) st <= S_ECHO_W;
          else begin
            if (lane_on) begin
              alive[lidx] <= 1'b0;
              lane_steps[lidx*STEP_W +: STEP_W] <= step - 1'b1;
              lane_result[lidx*2 +: 2] <= nak ? RES_NAK : RES_LIM;
            end
            if (lane_last) st <= S_ITER;
            else lidx <= lidx + 1'b1;
          end
        end
        S_ECHO_W: if (rsp_done) st <= S_ECHO_R;
        S_ECHO_R: if (rsp_done) begin
          if (rsp_rdata != IDLE_WORD) begin
            alive[lidx] <= 1'b0;
            lane_steps[lidx*STEP_W +: STEP_W] <= step - 1'b1;
            lane_result[lidx*2 +: 2] <= RES_LIM;
          end
          if (lane_last) st <= S_ITER;
          else begin
            lidx <= lidx + 1'b1;
            st <= S_STAT;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/margin_sweep_seq_chk.sv
module margin_sweep_seq_chk #(
  parameter int NUM_LANES = 32,
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   req,
  input logic                   req_write,
  input logic [LANE_W-1:0]      req_lane,
  input logic [15:0]            req_wdata,
  input logic                   rsp_done,
  input logic [NUM_LANES*7-1:0] lane_steps,
  input logic [NUM_LANES*2-1:0] lane_result,
  input logic [NUM_LANES-1:0]   alive
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !rsp_done |=> req && $stable(req_lane) && $stable(req_write) && $stable(req_wdata));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(lane_steps) && $stable(lane_result));

  // R6
  dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && req_write && (req_wdata[5:3] == 3'd3 || req_wdata[5:3] == 3'd4) |-> alive[req_lane]);

  // R1
  word_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && req_write |-> req_wdata[7:6] == 2'b00);

endmodule

bind margin_sweep_seq margin_sweep_seq_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .req(req),
  .req_write(req_write), .req_lane(req_lane), .req_wdata(req_wdata), .rsp_done(rsp_done),
  .lane_steps(lane_steps), .lane_result(lane_result), .alive(alive)
);

// File: tb/margin_sweep_seq_tb.sv
`timescale 1ns/1ps
module margin_sweep_seq_tb;
  localparam int NL = 32;
  localparam int LW = 5;
  localparam logic [15:0] IDLE_WORD = 16'h9C38;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] recv_sel = 0;
  logic [1:0] sweep_dir = 0;
  logic [LW:0] lane_cnt = 0;
  logic [6:0] step_total = 0;
  logic [5:0] err_limit = 0;
  logic [15:0] dwell_cycles = 0;
  logic req, req_write, busy, done;
  logic [LW-1:0] req_lane;
  logic [15:0] req_wdata;
  logic rsp_done = 0;
  logic [15:0] rsp_rdata = 0;
  logic [NL*7-1:0] lane_steps;
  logic [NL*2-1:0] lane_result;

  always #4 clk = ~clk;

  margin_sweep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .recv_sel(recv_sel), .sweep_dir(sweep_dir),
    .lane_cnt(lane_cnt), .step_total(step_total), .err_limit(err_limit),
    .dwell_cycles(dwell_cycles), .req(req), .req_write(req_write), .req_lane(req_lane),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .busy(busy),
    .done(done), .lane_steps(lane_steps), .lane_result(lane_result));

  int checks = 0, bad = 0, cyc = 0, done_cnt = 0;
  int fmode[NL], fstep[NL];
  logic [15:0] last_ctrl[NL];
  bit echo_bad[NL];
  logic [LW+15:0] wq[$];
  string wtag[$];
  logic [NL*7-1:0] qs[$];
  logic [NL*2-1:0] qr[$];
  int cur_lim, cur_recv, cur_dwell;

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stepw(int d, int s, int r);
    if (d < 2) return {1'b0, d == 0, 6'(s), 2'b00, 3'd3, 3'(r)};
    return {d == 3, 7'(s), 2'b00, 3'd4, 3'(r)};
  endfunction

  function automatic logic [15:0] status_for(int l);
    logic [15:0] w, o;
    int s;
    w = last_ctrl[l];
    if (w[5:3] != 3'd3 && w[5:3] != 3'd4) return echo_bad[l] ? 16'hFFFF : w;
    s = (w[5:3] == 3'd3) ? int'(w[13:8]) : int'(w[14:8]);
    o = {2'b10, 6'(cur_lim), 2'b00, w[5:3], 3'(cur_recv)};
    if (fmode[l] != 0 && s >= fstep[l]) begin
      case (fmode[l])
        1: o[15:14] = 2'd1;
        2: o[15:14] = 2'd3;
        3: o[13:8] = 6'(cur_lim + 1);
        4: o[15:14] = 2'd0;
        5: o[5:3] = 3'd5;
        7: o[2:0] = 3'(cur_recv ^ 1);
        default: ;
      endcase
    end
    return o;
  endfunction

  // lane-side register model and write monitor
  initial begin
    int lat = 0, wr_cyc = 0;
    bit step_pend = 0;
    logic [LW+15:0] hold, ew;
    forever begin
      @(negedge clk);
      rsp_done = 0;
      if (req) begin
        lat++;
        if (lat == 1) begin
          hold = {req_lane, req_wdata};
          if (!req_write && step_pend) begin
            chk(cyc - wr_cyc > cur_dwell, "R4", "dwell gap", cyc - wr_cyc, cur_dwell + 1);
            step_pend = 0;
          end
        end
        if (lat >= 2) begin
          lat = 0;
          rsp_done = 1;
          if (req_write) begin
            chk(hold == {req_lane, req_wdata}, "R12", "request stability", {req_lane, req_wdata}, hold);
            if (wq.size() == 0) chk(0, "R2", "unexpected write", {req_lane, req_wdata}, 0);
            else begin
              ew = wq.pop_front();
              chk(ew == {req_lane, req_wdata}, wtag.pop_front(), "write word", {req_lane, req_wdata}, ew);
            end
            echo_bad[req_lane] = (req_wdata == IDLE_WORD) && fmode[req_lane] == 6
              && (last_ctrl[req_lane][5:3] == 3'd3 || last_ctrl[req_lane][5:3] == 3'd4)
              && int'(last_ctrl[req_lane][14:8] & (last_ctrl[req_lane][5:3] == 3'd3 ? 7'h3F : 7'h7F)) >= fstep[req_lane];
            last_ctrl[req_lane] = req_wdata;
            if (req_wdata[5:3] == 3'd3 || req_wdata[5:3] == 3'd4) begin
              wr_cyc = cyc;
              step_pend = 1;
            end
          end else rsp_rdata = status_for(int'(req_lane));
        end
      end else lat = 0;
    end
  end

  // result monitor
  initial begin
    logic [NL*7-1:0] es;
    logic [NL*2-1:0] er;
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        chk(wq.size() == 0, "R2", "writes outstanding at done", wq.size(), 0);
        if (qs.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          es = qs.pop_front();
          er = qr.pop_front();
          for (int l = 0; l < NL; l++) begin
            string t;
            t = (er[l*2 +: 2] == 2'd1) ? "R7" : (er[l*2 +: 2] == 2'd0) ? "R11" : "R6";
            chk(lane_steps[l*7 +: 7] == es[l*7 +: 7] && lane_result[l*2 +: 2] == er[l*2 +: 2], t,
                $sformatf("lane %0d step/code", l),
                {lane_steps[l*7 +: 7], 6'd0, lane_result[l*2 +: 2]},
                {es[l*7 +: 7], 6'd0, er[l*2 +: 2]});
          end
        end
      end
    end
  end

  task automatic push_w(int l, logic [15:0] w, string t);
    wq.push_back({LW'(l), w});
    wtag.push_back(t);
  endtask

  task automatic run(int d, int n, int total, int lim, int dw, int r, bit poke);
    bit al[NL];
    logic [NL*7-1:0] es = '0;
    logic [NL*2-1:0] er = '0;
    int s = 0, target;
    bit any;
    for (int l = 0; l < n; l++) begin
      push_w(l, IDLE_WORD, "R1");
      push_w(l, {2'b11, 6'(lim), 2'b00, 3'd2, 3'(r)}, "R1");
      push_w(l, IDLE_WORD, "R1");
      al[l] = 1;
      es[l*7 +: 7] = 7'(total);
      er[l*2 +: 2] = 2'd1;
    end
    any = n > 0;
    while (any && s < total) begin
      s++;
      for (int l = 0; l < n; l++) if (al[l]) push_w(l, stepw(d, s, r), "R3");
      for (int l = 0; l < n; l++) if (al[l]) begin
        bit f;
        f = fmode[l] != 0 && s >= fstep[l];
        if (!f || fmode[l] == 6) push_w(l, IDLE_WORD, "R5");
        if (f) begin
          al[l] = 0;
          es[l*7 +: 7] = 7'(s - 1);
          er[l*2 +: 2] = (fmode[l] == 1 || fmode[l] == 2) ? 2'd2 : 2'd3;
        end
      end
      any = 0;
      for (int l = 0; l < n; l++) any |= al[l];
    end
    for (int l = 0; l < n; l++) begin
      push_w(l, IDLE_WORD, "R8");
      push_w(l, {8'h55, 2'b00, 3'd2, 3'(r)}, "R8");
      push_w(l, IDLE_WORD, "R8");
      push_w(l, {8'h0F, 2'b00, 3'd2, 3'(r)}, "R8");
      push_w(l, IDLE_WORD, "R8");
    end
    qs.push_back(es);
    qr.push_back(er);
    cur_lim = lim; cur_recv = r; cur_dwell = dw;
    target = done_cnt + 1;
    @(negedge clk);
    sweep_dir = 2'(d); lane_cnt = (LW+1)'(n); step_total = 7'(total);
    err_limit = 6'(lim); dwell_cycles = 16'(dw); recv_sel = 3'(r);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (10) @(negedge clk);
      recv_sel = 3'(r + 2); lane_cnt = 1; step_total = 1; sweep_dir = 2'(d + 1);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(busy == 1, "R10", "busy after start while busy", busy, 1);
    end
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R9", "done single pulse then idle", {done, busy}, 0);
    chk(done_cnt == target, "R10", "done count", done_cnt, target);
  endtask

  task automatic clear_modes();
    for (int l = 0; l < NL; l++) begin
      fmode[l] = 0;
      fstep[l] = 0;
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    logic [NL*7-1:0] ss;
    logic [NL*2-1:0] sr;
    for (int l = 0; l < NL; l++) begin
      last_ctrl[l] = 0;
      echo_bad[l] = 0;
    end
    clear_modes();
    fork
      begin
        repeat (5) @(negedge clk);
        chk(busy == 0 && done == 0 && req == 0, "R9", "reset state controls", {busy, done, req}, 0);
        chk(lane_steps == '0 && lane_result == '0, "R11", "reset results", 0, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(req == 0, "R9", "idle without start", req, 0);
        // timing-left: NAK, error-count limit, echo failure, survivor
        fmode[1] = 1; fstep[1] = 3;
        fmode[2] = 3; fstep[2] = 2;
        fmode[3] = 6; fstep[3] = 4;
        run(0, 4, 5, 4, 3, 1, 1);
        // voltage-down: all lanes die, sweep stops early
        clear_modes();
        fmode[0] = 2; fstep[0] = 5;
        fmode[1] = 5; fstep[1] = 1;
        fmode[2] = 7; fstep[2] = 4;
        run(3, 3, 100, 10, 0, 2, 0);
        // timing-right, zero total
        clear_modes();
        run(1, 2, 0, 0, 1, 6, 0);
        // voltage-up over all lanes
        fmode[7] = 4; fstep[7] = 2;
        fmode[31] = 2; fstep[31] = 1;
        run(2, 32, 2, 20, 5, 3, 0);
        // single lane, full timing range, limit zero
        clear_modes();
        run(0, 1, 63, 0, 2, 0, 0);
        ss = lane_steps; sr = lane_result;
        recv_sel = 5; lane_cnt = 7; step_total = 9; err_limit = 3;
        repeat (15) @(negedge clk);
        chk(lane_steps == ss && lane_result == sr, "R11", "results held while idle", 0, 0);
      end
      begin
        while (cyc < 150000) @(negedge clk);
        chk(0, "R9", "watchdog expired", cyc, 0);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule